// File: doc/BRIEF.md
# Epoch Token Controller for Live Routing Change

This block sits beside the input and output ports of one network-on-chip switch. It lets the switch move from an old routing function to a new one while traffic keeps flowing. A separation token travels along every channel and marks the point where old-epoch packets stop and new-epoch packets begin. Each input port keeps one epoch bit. Before its token arrives, the port takes only packets tagged old and routes them with the old function. Once the token arrives, the port takes only packets tagged new and routes them with the new function.

Tokens have to leave the switch in the dependency order of the old routing function. For this reason, each output has a mask that names the input ports whose tokens must be in before that output may send its own token. The output must also have no old packet still in flight. The start pulse loads these masks and clears every epoch bit, which arms a new reconfiguration. A done flag reports that every input port has changed over. Because no old packet can ever trail a token on a channel, the old and new routing functions never produce the mixed dependency cycles that cause deadlock.

Top module: `epoch_token_ctrl`

## Requirements
- R1: After reset, every routing select is 0 (old function), no output token is driven and the done flag is low.
- R2: When the controller is armed and no start is present, a token on an input port whose epoch bit is 0 sets that bit. From the next cycle, that port's routing select reads 1, meaning the new function.
- R3: While a port's epoch bit is 0, a valid packet is accepted in the same cycle only if its epoch tag is 0 (old). A packet tagged 1 (new) is held off.
- R4: While a port's epoch bit is 1, a valid packet is accepted only if its epoch tag is 1. A packet tagged 0 is held off.
- R5: Output o sends a token under four conditions: the controller is armed, output o has not yet sent its token in this reconfiguration, every input i with mask bit o*N_IN+i set has its epoch bit at 1, and the output's busy input is low. The token is a one-cycle pulse in the cycle after these conditions hold.
- R6: While an output's busy input (old packet in flight) is high, that output sends no token.
- R7: Each output sends at most one token per reconfiguration. A second token on an input port that has already changed over has no effect.
- R8: The done flag is high exactly when the controller is armed and every input epoch bit is 1.
- R9: A start pulse does four things at the next edge: it clears all epoch bits and sent flags, loads the masks, arms the controller and suppresses output tokens for that edge. A token that arrives in the same cycle as start is dropped. Tokens that arrive before the first start are ignored.
- R10: An output whose mask is all zeros sends its token in the cycle after the start edge, provided its busy input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new reconfiguration and loads the masks |
| cfg_mask_i | input | N_OUT*N_IN | Dependency masks; bit o*N_IN+i means output o waits on input i |
| tok_in_i | input | N_IN | Token arrival, one bit per input port |
| pkt_vld_i | input | N_IN | Packet present at each input port |
| pkt_tag_i | input | N_IN | Epoch tag of each presented packet (0 old, 1 new) |
| pkt_acc_o | output | N_IN | Packet accepted this cycle, per input port |
| out_busy_i | input | N_OUT | Old packet still in flight on each output |
| tok_out_o | output | N_OUT | One-cycle token pulse, per output |
| rsel_o | output | N_IN | Routing function select per input port (0 old, 1 new) |
| done_o | output | 1 | All input ports have changed over |

## Verification
On every cycle, the assertions check the local rules. A port's bit flips after an armed token. Start clears the epoch bits. A port never admits a packet from the wrong epoch. A token pulse lasts one cycle, and it only follows a cycle in which the busy input was low and the mask was satisfied. The done flag only rises after a token arrives. The bench's scenarios show the end-to-end ordering that no single-cycle property captures. These include outputs that wait on several inputs in turn, busy hold-off that delays a ready token, repeated tokens, tokens sent before arming, and back-to-back reconfigurations with fresh masks. Each of these is compared against a reference model of the requirements.

// File: rtl/epoch_token_pkg.sv
package epoch_token_pkg;
  typedef enum logic {
    EPOCH_OLD = 1'b0,
    EPOCH_NEW = 1'b1
  } epoch_e;
endpackage

// File: rtl/epoch_in_port.sv
module epoch_in_port
  import epoch_token_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic armed_i,
  input  logic tok_i,
  input  logic vld_i,
  input  logic tag_i,
  output logic epoch_o,
  output logic accept_o
);

  epoch_e epoch_q, epoch_d;
  logic   epoch_en;

  always_comb begin
    epoch_en = 1'b0;
    epoch_d  = epoch_q;
    if (start_i) begin
      epoch_en = 1'b1;
      epoch_d  = EPOCH_OLD;
    end else if (armed_i && tok_i && (epoch_q == EPOCH_OLD)) begin
      epoch_en = 1'b1;
      epoch_d  = EPOCH_NEW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        epoch_q <= EPOCH_OLD;
    else if (epoch_en) epoch_q <= epoch_d;
  end

  assign epoch_o  = (epoch_q == EPOCH_NEW);
  assign accept_o = vld_i && (tag_i == epoch_o);

  p_flip_on_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && tok_i && !start_i) |=> epoch_o);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !epoch_o);
  p_new_held_before_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !epoch_o) |-> !tag_i);
  p_old_held_after_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && epoch_o) |-> tag_i);

endmodule

// File: rtl/token_emitter.sv
module token_emitter #(
  parameter int N_IN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            armed_i,
  input  logic [N_IN-1:0] mask_cfg_i,
  input  logic [N_IN-1:0] flipped_i,
  input  logic            busy_i,
  output logic            tok_o
);

  logic [N_IN-1:0] mask_q;
  logic            sent_q, sent_d;
  logic            tok_q, tok_d;
  logic            deps_met;

  assign deps_met = ((mask_q & ~flipped_i) == '0);

  always_comb begin
    tok_d  = 1'b0;
    sent_d = sent_q;
    if (start_i) begin
      sent_d = 1'b0;
    end else if (armed_i && !sent_q && deps_met && !busy_i) begin
      tok_d  = 1'b1;
      sent_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (start_i) mask_q <= mask_cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
      tok_q  <= 1'b0;
    end else begin
      sent_q <= sent_d;
      tok_q  <= tok_d;
    end
  end

  assign tok_o = tok_q;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |=> !tok_o);
  p_busy_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |-> $past(!busy_i));
  p_mask_met_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |-> $past((mask_q & ~flipped_i) == '0));

endmodule

// File: rtl/epoch_token_ctrl.sv
module epoch_token_ctrl #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [N_OUT*N_IN-1:0]   cfg_mask_i,
  input  logic [N_IN-1:0]         tok_in_i,
  input  logic [N_IN-1:0]         pkt_vld_i,
  input  logic [N_IN-1:0]         pkt_tag_i,
  output logic [N_IN-1:0]         pkt_acc_o,
  input  logic [N_OUT-1:0]        out_busy_i,
  output logic [N_OUT-1:0]        tok_out_o,
  output logic [N_IN-1:0]         rsel_o,
  output logic                    done_o
);

  logic            armed_q;
  logic [N_IN-1:0] flipped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    epoch_in_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .armed_i  (armed_q),
      .tok_i    (tok_in_i[i]),
      .vld_i    (pkt_vld_i[i]),
      .tag_i    (pkt_tag_i[i]),
      .epoch_o  (flipped[i]),
      .accept_o (pkt_acc_o[i])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    token_emitter #(.N_IN(N_IN)) u_emit (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .armed_i    (armed_q),
      .mask_cfg_i (cfg_mask_i[o*N_IN +: N_IN]),
      .flipped_i  (flipped),
      .busy_i     (out_busy_i[o]),
      .tok_o      (tok_out_o[o])
    );
  end

  assign rsel_o = flipped;
  assign done_o = armed_q && (&flipped);

  p_done_after_token_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(|tok_in_i));

endmodule

// File: tb/epoch_token_ctrl_tb.sv
module epoch_token_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 5;
  localparam int NO = 5;

  logic clk, rst_n, start;
  logic [NO*NI-1:0] cfg;
  logic [NI-1:0] tok_in, vld, tag, acc, rsel;
  logic [NO-1:0] busy, tok_out;
  logic done;

  int errs = 0, checks = 0;

  logic [NI-1:0] m_ep;
  logic [NO-1:0] m_sent, m_tok;
  logic [NI-1:0] m_mask [NO];
  logic m_armed;

  epoch_token_ctrl #(.N_IN(NI), .N_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_mask_i(cfg),
    .tok_in_i(tok_in), .pkt_vld_i(vld), .pkt_tag_i(tag), .pkt_acc_o(acc),
    .out_busy_i(busy), .tok_out_o(tok_out), .rsel_o(rsel), .done_o(done));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NI-1:0] exp_accept(input logic [NI-1:0] v, input logic [NI-1:0] t,
                                              input logic [NI-1:0] ep);
    return v & ~(t ^ ep);
  endfunction

  function automatic logic exp_emit(input int o);
    return m_armed && !m_sent[o] && ((m_mask[o] & ~m_ep) == '0) && !busy[o];
  endfunction

  // inputs are driven just after a rising edge; this checks and advances one cycle
  task automatic step();
    logic [NO-1:0] em;
    #2;
    chk(acc === exp_accept(vld, tag, m_ep), "R3 R4 accept", acc, exp_accept(vld, tag, m_ep));
    for (int o = 0; o < NO; o++) em[o] = exp_emit(o);
    if (start) begin
      m_ep = '0; m_sent = '0; m_armed = 1'b1; m_tok = '0;
      for (int o = 0; o < NO; o++) m_mask[o] = cfg[o*NI +: NI];
    end else begin
      if (m_armed) m_ep = m_ep | tok_in;
      m_tok = em;
      m_sent = m_sent | em;
    end
    @(posedge clk); #1;
    chk(rsel === m_ep, "R2 R9 rsel", rsel, m_ep);
    chk(tok_out === m_tok, "R5 R6 R7 R10 tok_out", tok_out, m_tok);
    chk(done === (m_armed && (&m_ep)), "R8 done", done, m_armed && (&m_ep));
  endtask

  task automatic idle_in();
    start = 0; tok_in = '0; vld = '0; tag = '0; busy = '0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; cfg = '0; idle_in();
    m_ep = '0; m_sent = '0; m_tok = '0; m_armed = 0;
    for (int o = 0; o < NO; o++) m_mask[o] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(rsel === '0, "R1 rsel", rsel, 0);
    chk(tok_out === '0, "R1 tok_out", tok_out, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    @(posedge clk); #1;

    // R9: token before first start is ignored
    tok_in = 5'b00001; step(); idle_in();
    chk(rsel[0] === 1'b0, "R9 pre-start token ignored", rsel, 0);

    // directed reconfiguration: out0 waits {0,1}, out1 empty (R10), out2 all, out3/out4 {4}
    cfg = '0;
    cfg[0*NI +: NI] = 5'b00011;
    cfg[1*NI +: NI] = 5'b00000;
    cfg[2*NI +: NI] = 5'b11111;
    cfg[3*NI +: NI] = 5'b10000;
    cfg[4*NI +: NI] = 5'b10000;
    start = 1; busy = 5'b00100; tok_in = 5'b00010; step(); idle_in();
    chk(rsel[1] === 1'b0, "R9 token with start dropped", rsel, 0);
    busy = 5'b00100; step();
    chk(tok_out[1] === 1'b1, "R10 empty mask emits", tok_out, 5'b00010);
    // R3: new-tagged packet held before flip
    vld = 5'b00011; tag = 5'b00010; busy = 5'b00100; step();
    tok_in = 5'b00001; busy = 5'b00100; step();
    tok_in = 5'b00010; busy = 5'b00100; step();
    busy = 5'b00100; step();
    chk(tok_out[0] === 1'b1, "R5 out0 after inputs 0,1", tok_out, 5'b00001);
    // R4: old-tagged packet held after flip
    vld = 5'b00011; tag = 5'b00001; busy = 5'b00100; step();
    tok_in = 5'b11101; busy = 5'b00100; step(); // R7 repeat on port 0
    busy = 5'b00100; step();
    chk(tok_out[2] === 1'b0, "R6 busy holds out2", tok_out[2], 0);
    chk(done === 1'b1, "R8 done after all flipped", done, 1);
    step(); step();
    chk(tok_out === '0, "R7 no second token", tok_out, 0);

    // random phase with periodic restarts
    for (int n = 0; n < 600; n++) begin
      idle_in();
      if (n % 60 == 0) begin
        start = 1;
        for (int b = 0; b < NO*NI; b++) cfg[b] = ($urandom_range(0, 2) == 0);
      end
      for (int i = 0; i < NI; i++) begin
        tok_in[i] = ($urandom_range(0, 9) == 0);
        vld[i]    = $urandom_range(0, 1);
        tag[i]    = $urandom_range(0, 1);
      end
      for (int o = 0; o < NO; o++) busy[o] = ($urandom_range(0, 3) == 0);
      step();
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule